// File: doc/BRIEF.md
# NAND Command and Address Decoder

This block is the host-facing front end of a synthesizable NAND flash device model. On every clock edge where the write qualifier is high, it samples the chip-enable, command-latch and address-latch strobes together with the I/O bus. From these it keeps three pieces of state: the current command, the multi-byte address, and a column offset. When an operation is ready to start, it raises a one-cycle start pulse. The array, the output bus and the busy timing belong to other blocks, which act on these pulses and read the latched command, address and offset.

Two parameters pick the address-cycle rules. `LARGE_PAGE` selects 2048-byte pages with a 16-bit column field, instead of 512-byte pages with an 8-bit column. `CAP_MBIT` gives the device capacity. On large-page parts it decides whether a read or program starts on the fourth or the fifth address byte. A 16-bit bus variant turns the word column into a byte column.

All strobes and bus values are plain control pins sampled under `wr_en`. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `nand_cmd_decode`

## Requirements
- R1: A write is a command byte only when `ce_n` is low and `cle` is high. A write with `cle` high and `ce_n` high changes no output.
- R2: A write with `ale` high is an address byte, whatever the level of `ce_n`. Byte k (k = 0, 1, 2, …) lands at address bits [8k+7:8k], least significant byte first, and `addr_cycles` counts up by one, saturating at 7.
- R3: When the second address byte is taken, the whole address is shifted left by (bus width in bytes − 1). This turns a word column into a byte column.
- R4: Code 0x00 sets `cmd_code` to 0x00 and `col_offset` to 0. Code 0x01 sets `cmd_code` to 0x00 and `col_offset` to 0x100. Code 0x50 sets `cmd_code` to 0x00 and `col_offset` to the page size (2048 on large-page parts, 512 on small-page parts).
- R5: The cycle after the command byte is latched, each of the following raises exactly one one-cycle pulse: 0x70 raises `go_status`, 0x10 raises `go_program`, 0xD0 raises `go_erase` and 0xFF raises `go_reset`. At most one pulse output is high in any cycle.
- R6: Code 0xFF returns `cmd_code` to 0x00 and clears `addr`, `addr_cycles` and `col_offset`.
- R7: Every latched command clears `addr_cycles`, except 0xE0, which leaves the count unchanged.
- R8: The first address byte after command 0x90 raises `go_id`.
- R9: With `cmd_code` 0x00 or 0x80, the address byte that brings `addr_cycles` to the start count raises `go_read` or `go_load` respectively. The start count is 3 on small-page parts, 4 on large-page parts of 1024 Mbit or less, and 5 on larger large-page parts.
- R10: Code 0xD0 shifts the latched address left by 16 on large-page parts and by 8 on small-page parts.
- R11: On large-page parts, 0x30 received while `cmd_code` is 0x00 changes no output.
- R12: On large-page parts, 0x05 clears `addr` bits [15:0] and `addr_cycles`, and leaves `cmd_code` and `col_offset` unchanged.
- R13: On large-page parts, 0xE0 and 0x35 become `cmd_code` and raise `go_read` one cycle later.
- R14: Synchronous reset gives `cmd_code` 0x00, offset 0, address 0, count 0 and all pulses low. Cycles with `wr_en` low change no state and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Qualifier: the strobes and bus are sampled only when high |
| ce_n | input | 1 | Chip enable, active low (gates command bytes only) |
| cle | input | 1 | Command latch strobe |
| ale | input | 1 | Address latch strobe |
| io_in | input | BUS_W | Host I/O bus; the low byte carries codes and address bytes |
| cmd_code | output | 8 | Current command after remapping |
| col_offset | output | 12 | Column offset chosen by the read variant |
| addr | output | ADDR_W | Assembled address |
| addr_cycles | output | 3 | Address bytes taken since the last clearing command |
| go_read | output | 1 | Start a page read or random read |
| go_load | output | 1 | Program address complete; start taking program data |
| go_program | output | 1 | Program confirm |
| go_erase | output | 1 | Erase confirm; `addr` holds the full block address |
| go_status | output | 1 | Status read requested |
| go_id | output | 1 | Identification read requested |
| go_reset | output | 1 | Device reset command |

## Verification
The assertions assume two things about the inputs. First, `cle` and `ale` are never both high in the same qualified write; with both high, a reset or start pulse could coincide with a fresh address byte. Second, on a 16-bit bus the upper byte stays zero during writes, because only the low byte carries codes and addresses. The stimulus respects both. It drives either a command byte, an address byte, a data write with neither strobe, or an idle cycle, and it always drives the upper byte as zero. Within those limits it varies `ce_n` freely, including address bytes sent with the chip deselected. The mix includes the remapped read codes, the large-page-only codes, and an unknown code.

// File: rtl/nand_dec_pkg.sv
package nand_dec_pkg;

  localparam logic [7:0] OP_READ        = 8'h00;
  localparam logic [7:0] OP_READ_HI     = 8'h01;
  localparam logic [7:0] OP_READ_SPARE  = 8'h50;
  localparam logic [7:0] OP_READ_GO     = 8'h30;
  localparam logic [7:0] OP_RAND_SETUP  = 8'h05;
  localparam logic [7:0] OP_RAND_GO     = 8'hE0;
  localparam logic [7:0] OP_READ_NOSER  = 8'h35;
  localparam logic [7:0] OP_ID          = 8'h90;
  localparam logic [7:0] OP_RESET       = 8'hFF;
  localparam logic [7:0] OP_PROG_SETUP  = 8'h80;
  localparam logic [7:0] OP_PROG_GO     = 8'h10;
  localparam logic [7:0] OP_CACHE_GO    = 8'h15;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;

  // pulses raised directly by a latched command byte
  typedef struct packed {
    logic status;
    logic prog;
    logic erase;
    logic rnd_read;
    logic rst_cmd;
  } imm_pulse_t;

endpackage

// File: rtl/nand_cmd_latch.sv
module nand_cmd_latch
  import nand_dec_pkg::*;
#(
  parameter bit LARGE_PAGE = 1'b1,
  parameter int PAGE_BYTES = 2048,
  parameter int OFS_W      = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_byte,
  output logic [7:0]       cmd_q,
  output logic [7:0]       cmd_nxt,
  output logic [OFS_W-1:0] offset_q,
  output logic             clr_cnt,
  output logic             clr_col,
  output logic             swallow,
  output logic             erase_now,
  output logic             reset_now,
  output imm_pulse_t       imm_q
);

  logic             ign_go;
  logic             rnd_setup;
  logic             accept;
  logic [7:0]       mapped;
  logic [OFS_W-1:0] off_d;
  imm_pulse_t       imm_d;

  generate
    if (LARGE_PAGE) begin : g_large
      assign ign_go    = (cmd_q == OP_READ) && (cmd_byte == OP_READ_GO);
      assign rnd_setup = (cmd_byte == OP_RAND_SETUP);
    end else begin : g_small
      assign ign_go    = 1'b0;
      assign rnd_setup = 1'b0;
    end
  endgenerate

  assign accept  = cmd_wr && !ign_go && !rnd_setup;
  assign swallow = cmd_wr && (ign_go || rnd_setup);
  assign clr_col = cmd_wr && rnd_setup;

  always_comb begin
    mapped = cmd_byte;
    if (cmd_byte == OP_READ_HI || cmd_byte == OP_READ_SPARE) mapped = OP_READ;
  end

  assign erase_now = accept && (mapped == OP_ERASE_GO);
  assign reset_now = accept && (mapped == OP_RESET);
  assign clr_cnt   = accept && (mapped != OP_RAND_GO);

  always_comb begin
    cmd_nxt = cmd_q;
    if (accept) cmd_nxt = (mapped == OP_RESET) ? OP_READ : mapped;
  end

  always_comb begin
    off_d = offset_q;
    if (accept) begin
      unique case (cmd_byte)
        OP_READ:       off_d = '0;
        OP_READ_HI:    off_d = OFS_W'(256);
        OP_READ_SPARE: off_d = OFS_W'(PAGE_BYTES);
        OP_RESET:      off_d = '0;
        default:       off_d = offset_q;
      endcase
    end
  end

  always_comb begin
    imm_d.status   = accept && (mapped == OP_STATUS);
    imm_d.prog     = accept && (mapped == OP_PROG_GO);
    imm_d.erase    = erase_now;
    imm_d.rnd_read = accept && LARGE_PAGE &&
                     (mapped == OP_RAND_GO || mapped == OP_READ_NOSER);
    imm_d.rst_cmd  = reset_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= OP_READ;
      offset_q <= '0;
      imm_q    <= '0;
    end else begin
      cmd_q    <= cmd_nxt;
      offset_q <= off_d;
      imm_q    <= imm_d;
    end
  end

  AST_RESET_TO_READ: assert property (@(posedge clk) disable iff (rst)
    reset_now |=> (cmd_q == OP_READ) && (offset_q == '0)) else $error("reset cmd"); // R6

  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && ign_go) |=> $stable(cmd_q) && $stable(offset_q)) else $error("0x30"); // R11

endmodule

// File: rtl/nand_addr_asm.sv
module nand_addr_asm #(
  parameter int ADDR_W    = 40,
  parameter int BUS_BYTES = 1,
  parameter int ERASE_SH  = 16,
  parameter int COL_BITS  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_wr,
  input  logic [7:0]        addr_byte,
  input  logic              clr_cnt,
  input  logic              clr_col,
  input  logic              erase_now,
  input  logic              reset_now,
  output logic [ADDR_W-1:0] addr_q,
  output logic [2:0]        cnt_q,
  output logic [2:0]        cnt_nxt
);

  localparam int                COL_SH   = BUS_BYTES - 1;
  localparam logic [2:0]        CNT_MAX  = 3'd7;
  localparam logic [ADDR_W-1:0] BYTE_MSK = ADDR_W'(8'hFF);
  localparam logic [ADDR_W-1:0] KEEP_ROW = ~((ADDR_W'(1) << COL_BITS) - ADDR_W'(1));

  logic [ADDR_W-1:0] a_nxt;
  logic [5:0]        bitpos;

  always_comb begin
    a_nxt   = addr_q;
    cnt_nxt = cnt_q;
    if (reset_now) begin
      a_nxt   = '0;
      cnt_nxt = '0;
    end else if (erase_now) begin
      a_nxt = a_nxt << ERASE_SH;
    end
    if (clr_col) a_nxt = a_nxt & KEEP_ROW;
    if (clr_cnt || clr_col) cnt_nxt = '0;
    bitpos = {cnt_nxt, 3'b000};
    if (addr_wr) begin
      a_nxt   = (a_nxt & ~(BYTE_MSK << bitpos)) | (ADDR_W'(addr_byte) << bitpos);
      cnt_nxt = (cnt_nxt == CNT_MAX) ? cnt_nxt : cnt_nxt + 3'd1;
      if (cnt_nxt == 3'd2) a_nxt = a_nxt << COL_SH;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= a_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  AST_ERASE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (erase_now && !addr_wr && !clr_col) |=> addr_q == ($past(addr_q) << ERASE_SH)) else $error("erase shift"); // R10

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((clr_cnt || clr_col) && !addr_wr) |=> cnt_q == 3'd0) else $error("count clear"); // R7

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (addr_wr && !clr_cnt && !clr_col && !reset_now && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 3'd1) else $error("count step"); // R2

endmodule

// File: rtl/nand_start_gen.sv
module nand_start_gen
  import nand_dec_pkg::*;
#(
  parameter int N_GO = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       addr_wr,
  input  logic [2:0] cnt_nxt,
  input  logic [7:0] cmd_nxt,
  output logic       go_id_q,
  output logic       go_rd_q,
  output logic       go_load_q
);

  localparam logic [2:0] GO_CNT = 3'(N_GO);

  logic at_go;
  assign at_go = addr_wr && (cnt_nxt == GO_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      go_id_q   <= 1'b0;
      go_rd_q   <= 1'b0;
      go_load_q <= 1'b0;
    end else begin
      go_id_q   <= addr_wr && (cnt_nxt == 3'd1) && (cmd_nxt == OP_ID);
      go_rd_q   <= at_go && (cmd_nxt == OP_READ);
      go_load_q <= at_go && (cmd_nxt == OP_PROG_SETUP);
    end
  end

  AST_READ_ONCE: assert property (@(posedge clk) disable iff (rst)
    go_rd_q |=> !go_rd_q) else $error("read start twice"); // R9

  AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (rst)
    go_load_q |=> !go_load_q) else $error("load start twice"); // R9

endmodule

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
  import nand_dec_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter bit LARGE_PAGE = 1'b1,
  parameter int CAP_MBIT   = 2048,
  parameter int ADDR_W     = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              ce_n,
  input  logic              cle,
  input  logic              ale,
  input  logic [BUS_W-1:0]  io_in,
  output logic [7:0]        cmd_code,
  output logic [11:0]       col_offset,
  output logic [ADDR_W-1:0] addr,
  output logic [2:0]        addr_cycles,
  output logic              go_read,
  output logic              go_load,
  output logic              go_program,
  output logic              go_erase,
  output logic              go_status,
  output logic              go_id,
  output logic              go_reset
);

  localparam int BUS_BYTES  = BUS_W / 8;
  localparam int PAGE_BYTES = LARGE_PAGE ? 2048 : 512;
  localparam int N_GO       = LARGE_PAGE ? ((CAP_MBIT >= 2048) ? 5 : 4) : 3;
  localparam int ERASE_SH   = LARGE_PAGE ? 16 : 8;
  localparam int COL_BITS   = LARGE_PAGE ? 16 : 8;

  logic       cmd_wr, addr_wr;
  logic [7:0] bus_byte;
  logic [7:0] cmd_nxt;
  logic [2:0] cnt_nxt;
  logic       clr_cnt, clr_col, swallow, erase_now, reset_now;
  logic       go_rd_addr;
  imm_pulse_t imm_q;

  assign bus_byte = io_in[7:0];
  assign cmd_wr   = wr_en && !ce_n && cle;
  assign addr_wr  = wr_en && ale && !swallow;

  nand_cmd_latch #(
    .LARGE_PAGE (LARGE_PAGE),
    .PAGE_BYTES (PAGE_BYTES),
    .OFS_W      (12)
  ) u_cmd (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .cmd_byte  (bus_byte),
    .cmd_q     (cmd_code),
    .cmd_nxt   (cmd_nxt),
    .offset_q  (col_offset),
    .clr_cnt   (clr_cnt),
    .clr_col   (clr_col),
    .swallow   (swallow),
    .erase_now (erase_now),
    .reset_now (reset_now),
    .imm_q     (imm_q)
  );

  nand_addr_asm #(
    .ADDR_W    (ADDR_W),
    .BUS_BYTES (BUS_BYTES),
    .ERASE_SH  (ERASE_SH),
    .COL_BITS  (COL_BITS)
  ) u_addr (
    .clk       (clk),
    .rst       (rst),
    .addr_wr   (addr_wr),
    .addr_byte (bus_byte),
    .clr_cnt   (clr_cnt),
    .clr_col   (clr_col),
    .erase_now (erase_now),
    .reset_now (reset_now),
    .addr_q    (addr),
    .cnt_q     (addr_cycles),
    .cnt_nxt   (cnt_nxt)
  );

  nand_start_gen #(
    .N_GO (N_GO)
  ) u_start (
    .clk       (clk),
    .rst       (rst),
    .addr_wr   (addr_wr),
    .cnt_nxt   (cnt_nxt),
    .cmd_nxt   (cmd_nxt),
    .go_id_q   (go_id),
    .go_rd_q   (go_rd_addr),
    .go_load_q (go_load)
  );

  assign go_read    = go_rd_addr | imm_q.rnd_read;
  assign go_program = imm_q.prog;
  assign go_erase   = imm_q.erase;
  assign go_status  = imm_q.status;
  assign go_reset   = imm_q.rst_cmd;

  generate
    if (BUS_W > 8) begin : g_wide
      logic [BUS_W-9:0] hi_byte;
      assign hi_byte = io_in[BUS_W-1:8];
      AST_HI_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (cle || ale)) |-> hi_byte == '0) else $error("upper byte"); // R2
    end
  endgenerate

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({go_read, go_load, go_program, go_erase, go_status, go_id, go_reset})) else $error("pulses"); // R5

  AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (go_read || go_load || go_program || go_erase || go_status || go_id || go_reset) |-> $past(wr_en)) else $error("spurious"); // R14

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(addr) && $stable(cmd_code) && $stable(col_offset) && $stable(addr_cycles)) else $error("idle"); // R14

  AST_ID_FIRST: assert property (@(posedge clk) disable iff (rst)
    go_id |-> addr_cycles == 3'd1) else $error("id cycle"); // R8

  AST_READ_AT_GO: assert property (@(posedge clk) disable iff (rst)
    (go_read && cmd_code == OP_READ) |-> addr_cycles == 3'(N_GO)) else $error("read cycle"); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    go_reset |-> (addr == '0) && (addr_cycles == 3'd0) && (cmd_code == OP_READ)) else $error("reset"); // R6

endmodule

// File: tb/nand_cmd_decode_tb.sv
`timescale 1ns/1ps
module nand_cmd_decode_tb;

  localparam int AW = 40;

  typedef struct packed {
    logic [7:0]    cmd;
    logic [11:0]   off;
    logic [AW-1:0] addr;
    logic [2:0]    cnt;
    logic [6:0]    p;   // [6]read [5]load [4]program [3]erase [2]status [1]id [0]reset
  } obs_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, ce_n = 1'b1, cle = 1'b0, ale = 1'b0;
  logic [7:0] io8 = 8'h00;
  obs_t ob0, ob1, ob2;
  obs_t ex [3];

  bit lp_c  [3] = '{1'b1, 1'b1, 1'b0};
  int ngo_c [3] = '{5, 4, 3};
  int bws_c [3] = '{0, 1, 0};
  int pg_c  [3] = '{2048, 2048, 512};

  logic [7:0] codes [16] = '{8'h00, 8'h01, 8'h50, 8'h30, 8'h05, 8'hE0, 8'h35, 8'h90,
                             8'hFF, 8'h80, 8'h10, 8'h15, 8'h60, 8'hD0, 8'h70, 8'h3C};

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nand_cmd_decode u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ce_n(ce_n), .cle(cle), .ale(ale), .io_in(io8),
    .cmd_code(ob0.cmd), .col_offset(ob0.off), .addr(ob0.addr), .addr_cycles(ob0.cnt),
    .go_read(ob0.p[6]), .go_load(ob0.p[5]), .go_program(ob0.p[4]), .go_erase(ob0.p[3]),
    .go_status(ob0.p[2]), .go_id(ob0.p[1]), .go_reset(ob0.p[0]));

  nand_cmd_decode #(.BUS_W(16), .LARGE_PAGE(1'b1), .CAP_MBIT(1024), .ADDR_W(AW)) u_dut_mid (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ce_n(ce_n), .cle(cle), .ale(ale), .io_in({8'h00, io8}),
    .cmd_code(ob1.cmd), .col_offset(ob1.off), .addr(ob1.addr), .addr_cycles(ob1.cnt),
    .go_read(ob1.p[6]), .go_load(ob1.p[5]), .go_program(ob1.p[4]), .go_erase(ob1.p[3]),
    .go_status(ob1.p[2]), .go_id(ob1.p[1]), .go_reset(ob1.p[0]));

  nand_cmd_decode #(.BUS_W(8), .LARGE_PAGE(1'b0), .CAP_MBIT(128), .ADDR_W(AW)) u_dut_sp (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ce_n(ce_n), .cle(cle), .ale(ale), .io_in(io8),
    .cmd_code(ob2.cmd), .col_offset(ob2.off), .addr(ob2.addr), .addr_cycles(ob2.cnt),
    .go_read(ob2.p[6]), .go_load(ob2.p[5]), .go_program(ob2.p[4]), .go_erase(ob2.p[3]),
    .go_status(ob2.p[2]), .go_id(ob2.p[1]), .go_reset(ob2.p[0]));

  function automatic obs_t get_obs(int i);
    if (i == 0) return ob0;
    if (i == 1) return ob1;
    return ob2;
  endfunction

  // reference model, written from the requirements
  task automatic model_step(int i, bit cev, bit clev, bit alev, logic [7:0] b);
    logic [7:0]    v;
    bit            skip = 1'b0;
    logic [AW-1:0] a = ex[i].addr;
    logic [2:0]    c = ex[i].cnt;
    ex[i].p = '0;
    if (!cev && clev) begin
      if (lp_c[i] && ex[i].cmd == 8'h00 && b == 8'h30) skip = 1'b1;              // R11
      else if (lp_c[i] && b == 8'h05) begin                                      // R12
        a = a & ~AW'(16'hFFFF); c = 3'd0; skip = 1'b1;
      end else begin
        v = b;                                                                   // R4
        if (b == 8'h00) ex[i].off = 12'h000;
        else if (b == 8'h01) begin ex[i].off = 12'h100; v = 8'h00; end
        else if (b == 8'h50) begin ex[i].off = 12'(pg_c[i]); v = 8'h00; end
        ex[i].cmd = v;
        case (v)
          8'h70: ex[i].p[2] = 1'b1;
          8'h10: ex[i].p[4] = 1'b1;
          8'hD0: begin a = a << (lp_c[i] ? 16 : 8); ex[i].p[3] = 1'b1; end        // R10
          8'hE0, 8'h35: if (lp_c[i]) ex[i].p[6] = 1'b1;                           // R13
          8'hFF: begin ex[i].cmd = 8'h00; a = '0; c = 3'd0; ex[i].off = 12'h000; ex[i].p[0] = 1'b1; end
          default: ;
        endcase
        if (v != 8'hE0) c = 3'd0;                                                // R7
      end
    end
    if (!skip && alev) begin
      a = (a & ~(AW'(8'hFF) << (8 * c))) | (AW'(b) << (8 * c));
      if (c != 3'd7) c = c + 3'd1;
      if (c == 3'd1 && ex[i].cmd == 8'h90) ex[i].p[1] = 1'b1;
      if (c == 3'd2) a = a << bws_c[i];                                          // R3
      if (c == 3'(ngo_c[i])) begin
        if (ex[i].cmd == 8'h00) ex[i].p[6] = 1'b1;
        if (ex[i].cmd == 8'h80) ex[i].p[5] = 1'b1;
      end
    end
    ex[i].addr = a;
    ex[i].cnt  = c;
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 3; i++) begin
      obs_t g = get_obs(i);
      checks++;
      if (g !== ex[i]) begin
        bad++;
        $display("FAIL %s inst%0d got cmd=%h off=%h addr=%h cnt=%0d p=%b exp cmd=%h off=%h addr=%h cnt=%0d p=%b",
                 tag, i, g.cmd, g.off, g.addr, g.cnt, g.p,
                 ex[i].cmd, ex[i].off, ex[i].addr, ex[i].cnt, ex[i].p);
      end
    end
  endtask

  task automatic bus_write(bit cev, bit clev, bit alev, logic [7:0] b, string tag);
    ce_n = cev; cle = clev; ale = alev; io8 = b; wr_en = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 3; i++) model_step(i, cev, clev, alev, b);
    @(negedge clk);
    wr_en = 1'b0; cle = 1'b0; ale = 1'b0; ce_n = 1'b1;
    check_all(tag);
  endtask

  task automatic cmd(logic [7:0] b, string tag);
    bus_write(1'b0, 1'b1, 1'b0, b, tag);
  endtask

  task automatic adr(logic [7:0] b, string tag);
    bus_write(1'b0, 1'b0, 1'b1, b, tag);
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) begin
      io8 = 8'($urandom);
      @(posedge clk);
      for (int i = 0; i < 3; i++) ex[i].p = '0;
      @(negedge clk);
      check_all(tag);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 3; i++) ex[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check_all("R14 reset state");

    // read address phase: start on byte 3 / 4 / 5 depending on the part
    cmd(8'h00, "R4 read");
    adr(8'h12, "R2 addr byte0");
    adr(8'h34, "R3 addr byte1 column shift");
    adr(8'h56, "R9 byte2");
    adr(8'h78, "R9 byte3");
    adr(8'h9A, "R9 byte4");
    adr(8'hBC, "R2 byte5");
    idle(2, "R14 idle hold");

    // identification
    cmd(8'h90, "R7 id command");
    adr(8'h00, "R8 id start");

    // read variants
    cmd(8'h01, "R4 second half");
    cmd(8'h50, "R4 spare");
    cmd(8'h00, "R4 plain read");

    // chip deselected: command ignored, address still taken
    bus_write(1'b1, 1'b1, 1'b0, 8'h70, "R1 deselected command");
    bus_write(1'b1, 1'b0, 1'b1, 8'h44, "R2 address with ce_n high");
    bus_write(1'b0, 1'b0, 1'b0, 8'hEE, "R14 data write no strobe");

    // erase
    cmd(8'h60, "R7 erase setup");
    adr(8'h21, "R10 row0");
    adr(8'h43, "R10 row1");
    adr(8'h65, "R10 row2");
    cmd(8'hD0, "R10 erase confirm");

    // large-page read confirm ignored
    cmd(8'h00, "R4 read");
    adr(8'hAA, "R2 col");
    cmd(8'h30, "R11 confirm ignored");

    // random read
    adr(8'h11, "R2");
    adr(8'h22, "R2");
    adr(8'h33, "R2");
    cmd(8'h05, "R12 random setup");
    adr(8'h7E, "R12 new column0");
    adr(8'h01, "R12 new column1");
    cmd(8'hE0, "R13 random confirm");
    adr(8'h5A, "R7 count kept over E0");
    cmd(8'h35, "R13 no-serial read");

    // program, status, reset
    cmd(8'h80, "R9 program setup");
    for (int k = 0; k < 5; k++) adr(8'(8'h10 + k), "R9 program address");
    cmd(8'h10, "R5 program confirm");
    cmd(8'h70, "R5 status");
    cmd(8'h15, "R7 cache confirm");
    cmd(8'hFF, "R6 reset command");
    idle(1, "R5 pulse one cycle");

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int r = int'($urandom_range(0, 9));
      if (r < 4)      bus_write($urandom_range(0, 5) == 0, 1'b0, 1'b1, 8'($urandom), "R2 R3 R9 random address");
      else if (r < 8) bus_write($urandom_range(0, 7) == 0, 1'b1, 1'b0, codes[$urandom_range(0, 15)], "R1 R4 R7 random command");
      else if (r == 8) bus_write(1'b0, 1'b0, 1'b0, 8'($urandom), "R14 random data");
      else idle(1, "R14 random idle");
    end

    // synchronous reset mid-stream
    cmd(8'h90, "R7");
    adr(8'h66, "R8");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) ex[i] = '0;
    check_all("R14 reset again");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL R14 watchdog expired got running exp finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule